// File: doc/BRIEF.md
# Stepped Clock Gear Divider

This block runs on a fast input clock and produces a clock enable whose period is stepped, one input period at a time, between a slow start ratio and a fast target ratio. A gear-up request walks the ratio from the slow setting down to the fast setting. A gear-down request walks it back up from the fast setting to the slow one. Each stage holds its ratio for a number of output periods that grows with the stage index and is scaled by a step multiplier. The load seen by the clocked logic therefore changes gradually instead of in one jump.

Stage k lasts k × mul output periods. The ratio changes only on a period boundary. When the ratio reaches its end value, the busy flag drops, the done flag rises, and the enable keeps running at that end ratio. A second, free-running divider always emits an enable at the target ratio, independent of the gearing. Settings are captured when a request is accepted. Requests with an invalid setting, and requests that arrive while a ramp is in progress, are dropped.

Top module: `gear_ramp_div`

## Requirements
- R1: A request is accepted only when the slow ratio is even, the slow ratio is greater than the fast ratio, the fast ratio is at least 1, and the multiplier is at least 1. Any other request is ignored: busy stays low and the enable pattern is unchanged.
- R2: Gear-up stage k (k = 1, 2, …) divides by slow − k + 1 and lasts k × mul enable periods. Starting from a stopped output, the first enable pulse comes slow input cycles after the accepting edge.
- R3: Gear-down stage k divides by fast + k − 1 and lasts k × mul enable periods.
- R4: The ramp ends at the edge where the ratio moves into its end value (fast for gear-up, slow for gear-down). At that edge busy falls and done rises. The enable then repeats at the end ratio indefinitely. Done is cleared by the next accepted request.
- R5: Busy stays high for exactly the sum, over every stage before the final one, of k × mul × (stage ratio) input cycles, plus any wait for a boundary (R6).
- R6: gear_en_o is one input cycle wide per divided period, and the ratio changes only at a period boundary. If the output is already running, a newly accepted ramp starts at the next pulse. A pulse in the accepting cycle counts as that boundary.
- R7: ref_en_o pulses once every fast-ratio input cycles (a value of 0 is treated as 1), free-running from reset and independent of the gearing.
- R8: If up and down requests arrive in the same cycle with a valid setting, gear-up is performed.
- R9: Changing the ratio or multiplier inputs during a ramp does not change that ramp.
- R10: While reset is asserted, busy_o, done_o and gear_en_o are low.
- R11: A request seen while busy is ignored. This includes a request in the cycle whose edge completes the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_div_i | input | DIV_W | Slow ratio (input periods per output period) |
| target_div_i | input | DIV_W | Fast ratio, also used by the reference divider |
| step_mul_i | input | MUL_W | Per-stage period multiplier |
| up_req_i | input | 1 | Gear-up request, sampled each cycle |
| down_req_i | input | 1 | Gear-down request, sampled each cycle |
| gear_en_o | output | 1 | Stepped divided enable, one cycle per period |
| ref_en_o | output | 1 | Fixed enable at the fast ratio |
| busy_o | output | 1 | Ramp in progress, including a wait for a boundary |
| done_o | output | 1 | The last ramp reached its end ratio |

## Verification
Two functions can land on the same edge: a new request being accepted, and the sequencer's final stage transition. The bench drives a valid request in exactly the cycle of the ramp's last pulse. Busy must then fall, done must rise, and no new ramp may begin. A request one cycle later must be accepted but held until the next enable pulse. A second collision, a valid up request together with a down request in one cycle, must be resolved as gear-up. Both cases are judged by the exact cycle of every enable pulse and the busy and done levels, all computed arithmetically in the bench.

// File: rtl/gear_pkg.sv
package gear_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PEND = 2'd1,
    SEQ_RAMP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/gear_period.sv
module gear_period #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             pulse_o
);
  logic [DIV_W-1:0] cnt_q;

  assign pulse_o = run_i && (cnt_q >= ratio_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || pulse_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // a period longer than one cycle never yields back-to-back pulses
  p_one_wide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && ratio_i > DIV_W'(1)) |=> (!pulse_o || ratio_i == DIV_W'(1)));
endmodule

// File: rtl/gear_cfg_check.sv
module gear_cfg_check #(
  parameter int DIV_W = 8,
  parameter int MUL_W = 4
) (
  input  logic [DIV_W-1:0] start_i,
  input  logic [DIV_W-1:0] target_i,
  input  logic [MUL_W-1:0] mul_i,
  input  logic             up_req_i,
  input  logic             down_req_i,
  input  logic             busy_i,
  output logic             acc_up_o,
  output logic             acc_dn_o
);
  logic cfg_ok;
  logic req_ok;

  assign cfg_ok   = (start_i > target_i) && (target_i != '0) && !start_i[0] && (mul_i != '0);
  assign req_ok   = cfg_ok && !busy_i;
  assign acc_up_o = req_ok && up_req_i;
  assign acc_dn_o = req_ok && down_req_i && !up_req_i;  // up wins
endmodule

// File: rtl/gear_seq.sv
module gear_seq
  import gear_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int MUL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_up_i,
  input  logic             acc_dn_i,
  input  logic [DIV_W-1:0] start_i,
  input  logic [DIV_W-1:0] target_i,
  input  logic [MUL_W-1:0] mul_i,
  input  logic             pulse_i,
  output logic [DIV_W-1:0] ratio_o,
  output logic             run_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int LEN_W = DIV_W + MUL_W;

  seq_state_e       state_q;
  logic [DIV_W-1:0] ratio_q, first_q, end_q, step_ratio, first_d;
  logic [MUL_W-1:0] mul_q;
  logic [LEN_W-1:0] len_q, per_q;
  logic             up_q, run_q, done_q, accept, stage_end;

  assign accept     = acc_up_i || acc_dn_i;
  assign first_d    = acc_up_i ? start_i : target_i;
  assign step_ratio = up_q ? ratio_q - 1'b1 : ratio_q + 1'b1;
  assign stage_end  = (per_q == len_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ratio_q <= '0;
      first_q <= '0;
      end_q   <= '0;
      mul_q   <= '0;
      len_q   <= '0;
      per_q   <= '0;
      up_q    <= 1'b0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (accept) begin
          up_q   <= acc_up_i;
          mul_q  <= mul_i;
          end_q  <= acc_up_i ? target_i : start_i;
          done_q <= 1'b0;
          if (!run_q || pulse_i) begin
            ratio_q <= first_d;
            len_q   <= LEN_W'(mul_i);
            per_q   <= '0;
            run_q   <= 1'b1;
            state_q <= SEQ_RAMP;
          end else begin
            first_q <= first_d;
            state_q <= SEQ_PEND;
          end
        end
        SEQ_PEND: if (pulse_i) begin
          ratio_q <= first_q;
          len_q   <= LEN_W'(mul_q);
          per_q   <= '0;
          state_q <= SEQ_RAMP;
        end
        SEQ_RAMP: if (pulse_i) begin
          if (stage_end) begin
            ratio_q <= step_ratio;
            len_q   <= len_q + LEN_W'(mul_q);  // k*mul built by accumulation
            per_q   <= '0;
            if (step_ratio == end_q) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end
          end else begin
            per_q <= per_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign ratio_o = ratio_q;
  assign run_o   = run_q;
  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = done_q;

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !acc_up_i && !acc_dn_i) |=> !busy_o);
  p_ratio_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RAMP && $past(state_q) == SEQ_RAMP && ratio_q != $past(ratio_q))
      |-> (ratio_q == $past(ratio_q) + 1'b1 || ratio_q + 1'b1 == $past(ratio_q)));
  p_arrive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && ratio_q == end_q));
  p_busy_done_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && ratio_q != $past(ratio_q)) |-> $past(pulse_i));
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(mul_q) && $stable(end_q) && $stable(up_q)));
endmodule

// File: rtl/gear_ramp_div.sv
module gear_ramp_div #(
  parameter int DIV_W = 8,
  parameter int MUL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] start_div_i,
  input  logic [DIV_W-1:0] target_div_i,
  input  logic [MUL_W-1:0] step_mul_i,
  input  logic             up_req_i,
  input  logic             down_req_i,
  output logic             gear_en_o,
  output logic             ref_en_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             acc_up, acc_dn, gear_run, busy;
  logic [DIV_W-1:0] gear_ratio, ref_ratio;

  assign ref_ratio = (target_div_i == '0) ? DIV_W'(1) : target_div_i;

  gear_cfg_check #(.DIV_W(DIV_W), .MUL_W(MUL_W)) u_cfg (
    .start_i   (start_div_i),
    .target_i  (target_div_i),
    .mul_i     (step_mul_i),
    .up_req_i  (up_req_i),
    .down_req_i(down_req_i),
    .busy_i    (busy),
    .acc_up_o  (acc_up),
    .acc_dn_o  (acc_dn)
  );

  gear_seq #(.DIV_W(DIV_W), .MUL_W(MUL_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_up_i(acc_up),
    .acc_dn_i(acc_dn),
    .start_i (start_div_i),
    .target_i(target_div_i),
    .mul_i   (step_mul_i),
    .pulse_i (gear_en_o),
    .ratio_o (gear_ratio),
    .run_o   (gear_run),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  gear_period #(.DIV_W(DIV_W)) u_gear (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (gear_run),
    .ratio_i(gear_ratio),
    .pulse_o(gear_en_o)
  );

  gear_period #(.DIV_W(DIV_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (1'b1),
    .ratio_i(ref_ratio),
    .pulse_o(ref_en_o)
  );

  assign busy_o = busy;

  p_req_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(acc_up || acc_dn));
endmodule

// File: tb/gear_ramp_div_tb.sv
`timescale 1ns/1ps
module gear_ramp_div_tb;
  localparam int DW = 5;
  localparam int MW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] start_div = '0;
  logic [DW-1:0] target_div = '0;
  logic [MW-1:0] step_mul = '0;
  logic          up_req = 1'b0;
  logic          down_req = 1'b0;
  logic          gear_en_o, ref_en_o, busy_o, done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  gear_ramp_div #(.DIV_W(DW), .MUL_W(MW)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_div_i (start_div),
    .target_div_i(target_div),
    .step_mul_i  (step_mul),
    .up_req_i    (up_req),
    .down_req_i  (down_req),
    .gear_en_o   (gear_en_o),
    .ref_en_o    (ref_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    up_req = 1'b0;
    down_req = 1'b0;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !gear_en_o, "R10", "outputs in reset",
        int'({busy_o, done_o, gear_en_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // caller stands at a negedge; the request is seen by the next posedge
  task automatic run_ramp(input bit up, input bit both, input bit was_run, input bit perturb,
                          input bit hit_end, input int g, input int m, input int mul, input string rq);
    int t, base, k, r, e, pd, exp_t, s_end, busy_cnt, tail, bad_pulse, bad_flag, exp_len, nst;
    bit fin, en;
    start_div  = DW'(g);
    target_div = DW'(m);
    step_mul   = MW'(mul);
    exp_len = 0;
    nst = g - m + 1;
    for (int kk = 1; kk < nst; kk++)
      exp_len += kk * mul * (up ? g - kk + 1 : m + kk - 1);
    up_req   = up | both;
    down_req = !up | both;
    base = (was_run && !gear_en_o) ? -1 : 0;
    k = 1; pd = 0; fin = 0; s_end = 0; tail = 0; t = 0;
    busy_cnt = 0; bad_pulse = 0; bad_flag = 0;
    r = up ? g : m;
    e = up ? m : g;
    exp_t = r;
    while (tail < 3 && t < 4000) begin
      @(negedge clk_i);
      t++;
      if (t == 1) begin up_req = 1'b0; down_req = 1'b0; end
      if (hit_end && fin && t == s_end + 1) down_req = 1'b0;
      if (perturb && t == 3) begin start_div = DW'(30); target_div = DW'(1); step_mul = MW'(3); end
      en = gear_en_o;
      if (busy_o) busy_cnt++;
      if (base < 0) begin
        if (!busy_o || done_o) bad_flag++;
        if (en) begin base = t; exp_t = t + r; end
      end else begin
        if (en != (t == exp_t)) bad_pulse++;
        if (t == exp_t) begin
          if (fin) tail++;
          else begin
            pd++;
            if (pd == k * mul) begin
              k++; pd = 0;
              r = up ? r - 1 : r + 1;
              if (r == e) begin
                fin = 1; s_end = t;
                if (hit_end) down_req = 1'b1;  // collides with the final transition
              end
            end
          end
          exp_t = t + r;
        end
        if (fin && t > s_end) begin
          if (busy_o || !done_o) bad_flag++;
        end else begin
          if (!busy_o || done_o) bad_flag++;
        end
      end
    end
    chk(bad_pulse == 0 && tail == 3, up ? "R2/R6" : "R3/R6", {rq, " pulse timing mismatches"}, bad_pulse, 0);
    chk(s_end - base == exp_len, "R5", {rq, " ramp length"}, s_end - base, exp_len);
    chk(busy_cnt == s_end, "R5", {rq, " busy cycles"}, busy_cnt, s_end);
    chk(bad_flag == 0, "R4", {rq, " busy/done levels"}, bad_flag, 0);
  endtask

  // e = 0: output stopped, else expected steady period
  task automatic ignored(input int g, input int m, input int mul, input int e, input string rq);
    int last, bad;
    start_div  = DW'(g);
    target_div = DW'(m);
    step_mul   = MW'(mul);
    up_req = 1'b1;
    down_req = 1'b1;
    last = -1; bad = 0;
    for (int t = 1; t <= 40; t++) begin
      @(negedge clk_i);
      if (t == 1) begin up_req = 1'b0; down_req = 1'b0; end
      if (busy_o) bad++;
      if (gear_en_o) begin
        if (e == 0) bad++;
        else if (last >= 0 && t - last != e) bad++;
        last = t;
      end
    end
    chk(bad == 0, rq, "request not ignored", bad, 0);
  endtask

  task automatic ref_check(input int m);
    int last, nint, bad;
    target_div = DW'(m);
    do_reset();
    last = -1; nint = 0; bad = 0;
    for (int t = 1; t <= 40; t++) begin
      @(negedge clk_i);
      if (ref_en_o) begin
        if (last >= 0) begin
          nint++;
          if (t - last != m) bad++;
        end
        last = t;
      end
    end
    chk(bad == 0 && nint >= 3, "R7", "ref period", bad, 0);
  endtask

  initial begin
    ref_check(1);
    ref_check(3);
    ref_check(4);

    // sweep of all valid small settings, both directions, from a stopped output
    for (int g = 2; g <= 8; g += 2)
      for (int m = 1; m < g; m++)
        for (int mul = 1; mul <= 3; mul++)
          for (int d = 0; d < 2; d++) begin
            do_reset();
            run_ramp(d == 0, 0, 0, 0, 0, g, m, mul, d == 0 ? "R2 sweep" : "R3 sweep");
          end

    // invalid settings (R1)
    do_reset(); ignored(7, 2, 1, 0, "R1 odd slow ratio");
    do_reset(); ignored(4, 4, 1, 0, "R1 equal ratios");
    do_reset(); ignored(4, 6, 1, 0, "R1 slow below fast");
    do_reset(); ignored(4, 0, 1, 0, "R1 fast ratio zero");
    do_reset(); ignored(6, 2, 0, 0, "R1 multiplier zero");

    // R11 request on the arrival edge, then R6 deferred start while running
    do_reset();
    run_ramp(1, 0, 0, 0, 1, 6, 2, 1, "R11 arrival collision");
    ignored(5, 2, 1, 2, "R1 invalid while running");
    run_ramp(0, 0, 1, 0, 0, 6, 2, 1, "R6 deferred gear-down");
    ignored(6, 6, 1, 6, "R1 invalid at slow ratio");
    run_ramp(1, 0, 1, 0, 0, 8, 3, 2, "R6 deferred gear-up");

    // R8 simultaneous requests, R9 inputs disturbed mid-ramp
    do_reset();
    run_ramp(1, 1, 0, 0, 0, 6, 1, 1, "R8 both requests");
    do_reset();
    run_ramp(1, 0, 0, 1, 0, 8, 3, 2, "R9 perturbed gear-up");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1-wide run: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule